// File: doc/BRIEF.md
# SPI Master Shifter with Locked Configuration

This block is a single-word SPI master. A host writes the bit rate, word size, clock polarity, clock phase and bit order through a small register write port. Those writes are accepted only while the configuration-mode input is high and the shifter is idle. A one-cycle `start` pulse loads `tx_data` and starts a transfer. The block then drives chip select, the serial clock and the output data line. It samples the input data line and returns the received word together with a one-cycle `done` pulse.

The serial clock half period is `rate + 1` master-clock cycles, so one full SCLK period is `2·(rate+1)` cycles. A transfer is refused in three cases: the rate is zero, the size field holds anything other than 8 or 16, or a transfer is already running. Reset clears every field, so the block cannot transfer until it has been programmed.

Top module: `spi_master_shifter`

## Requirements
- R1: After reset all configuration fields are zero, `spi_cs_n` is 1, `busy`, `done` and `spi_sclk` are 0, and a `start` pulse is refused (busy stays 0).
- R2: Configuration writes take effect only when `cfg_mode` is 1 and `busy` is 0. Other writes are ignored. Address 0 holds phase in bit 0, polarity in bit 1 and bit order in bit 2. Address 1 holds the rate in bits 15:8 and the size in bits 4:0.
- R3: While the rate field is zero, `start` is refused.
- R4: While the size field is neither 8 nor 16, `start` is refused.
- R5: An accepted transfer of N bits produces exactly 2·N SCLK edges, spaced rate+1 cycles apart.
- R6: When idle, SCLK rests at the polarity bit (0 gives a low idle level, 1 gives a high one). The first edge of each bit moves SCLK away from that level.
- R7: With phase 0, the first data bit is on MOSI in the cycle chip select falls. The peripheral samples on the first edge of each bit and MOSI changes on the second. With phase 1, MOSI changes on the first edge and the peripheral samples on the second.
- R8: Bit order 1 sends and receives the most significant bit first. Bit order 0 sends and receives the least significant bit first. An 8-bit received word is right-justified in `rx_data`, with bits 15:8 at zero.
- R9: Chip select falls in the cycle after `start` is accepted. The first SCLK edge follows rate+1 cycles later. Chip select rises rate+1 cycles after the last edge, in the same cycle as a one-cycle `done` pulse that comes with the updated `rx_data`.
- R10: A `start` pulse during a transfer is ignored. It neither alters the word in flight nor begins a new transfer afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Configuration mode; enables register writes while idle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select (0 mode bits, 1 rate and size) |
| reg_wdata | input | 16 | Register write data |
| start | input | 1 | Start pulse for one transfer |
| tx_data | input | 16 | Word to transmit (low 8 bits for 8-bit transfers) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| rx_data | output | 16 | Last received word, right-justified |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data in |

## Verification
Taking the accepting edge as cycle T, chip select and busy are due at T. The edges are due at T+k·(rate+1) for k = 1 to 2N, and chip select release with `done` is due at T+(2N+1)·(rate+1). The bench counts clock cycles and samples every output on the falling clock edge. It stamps each observed SCLK toggle with the cycle count and compares the gaps against rate+1. It acts as the peripheral: it drives MISO on the edge opposite to the sampling edge and checks MOSI on the sampling edge. One cycle after `done`, it confirms that the pulse has ended, that no new transfer started and that SCLK rests at the idle level.

// File: rtl/spi_master_shifter.sv
module spi_master_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_mode,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        start,
  input  logic [15:0] tx_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rx_data,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso
);

  logic       pha, pol, msb_first;
  logic [7:0] rate;
  logic [4:0] size;
  logic [7:0] cnt;
  logic [5:0] step;
  logic [15:0] txs, rxs, rx_in;
  logic       sclk_t;
  logic       unused_bits;

  assign unused_bits = ^reg_wdata[7:3];

  wire cfg_we   = reg_wr && cfg_mode && !busy;
  wire wide     = (size == 5'd16);
  wire cfg_ok   = (rate != 8'd0) && (wide || size == 5'd8);
  wire go       = start && !busy && cfg_ok;
  wire tick     = busy && (cnt == 8'd0);
  wire [5:0] nedge = wide ? 6'd32 : 6'd16;
  wire edge_now = tick && (step < nedge);
  wire lead     = ~step[0];
  wire smp      = edge_now && (pha ? !lead : lead);
  wire shf      = edge_now && (pha ? (lead && step != 6'd0) : !lead);

  assign spi_sclk = sclk_t ^ pol;
  assign spi_mosi = msb_first ? (wide ? txs[15] : txs[7]) : txs[0];

  always_comb begin
    if (msb_first)
      rx_in = {rxs[14:0], spi_miso};
    else if (wide)
      rx_in = {spi_miso, rxs[15:1]};
    else
      rx_in = {8'h00, spi_miso, rxs[7:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pha <= 1'b0; pol <= 1'b0; msb_first <= 1'b0;
      rate <= 8'd0; size <= 5'd0;
    end else if (cfg_we) begin
      if (reg_addr) begin
        rate <= reg_wdata[15:8];
        size <= reg_wdata[4:0];
      end else begin
        pha <= reg_wdata[0];
        pol <= reg_wdata[1];
        msb_first <= reg_wdata[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; spi_cs_n <= 1'b1; sclk_t <= 1'b0;
      cnt <= 8'd0; step <= 6'd0; txs <= 16'd0; rxs <= 16'd0; rx_data <= 16'd0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1; spi_cs_n <= 1'b0;
        cnt <= rate; step <= 6'd0;
        txs <= tx_data; rxs <= 16'd0;
      end else if (tick) begin
        cnt <= rate;
        step <= step + 6'd1;
        if (edge_now) sclk_t <= ~sclk_t;
        if (smp) rxs <= rx_in;
        if (shf) txs <= msb_first ? {txs[14:0], 1'b0} : {1'b0, txs[15:1]};
        if (step == nedge) begin
          busy <= 1'b0; spi_cs_n <= 1'b1; done <= 1'b1; rx_data <= rxs;
        end
      end else if (busy) begin
        cnt <= cnt - 8'd1;
      end
    end
  end

  assert_cfg_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode || busy) |=> $stable({pha, pol, msb_first, rate, size}));

  assert_zero_rate_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rate == 8'd0) |=> !busy);

  assert_bad_size_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && size != 5'd8 && size != 5'd16) |=> !busy);

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sclk == pol);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);

  assert_busy_progress_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done || (busy && step >= $past(step)));

endmodule

// File: tb/spi_master_shifter_bench.sv
module spi_master_shifter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0, start = 1'b0, spi_miso = 1'b0;
  logic [15:0] reg_wdata = 16'd0, tx_data = 16'd0;
  logic busy, done, spi_sclk, spi_mosi, spi_cs_n;
  logic [15:0] rx_data;
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_master_shifter u_spi_master_shifter (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .start(start), .tx_data(tx_data), .busy(busy), .done(done),
    .rx_data(rx_data), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .spi_miso(spi_miso));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit wbit(input logic [15:0] w, input int n, input bit msb, input int k);
    return msb ? w[n-1-k] : w[k];
  endfunction

  task automatic wr(input bit a, input logic [15:0] d, input bit cfg);
    @(negedge clk); cfg_mode = cfg; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; cfg_mode = 1'b0;
  endtask

  task automatic setup(input bit pha, input bit pol, input bit msb, input int rate, input int size);
    wr(1'b0, {13'd0, msb, pol, pha}, 1'b1);
    wr(1'b1, {rate[7:0], 3'b000, size[4:0]}, 1'b1);
  endtask

  task automatic try_refused(input string tag);
    @(negedge clk); start = 1'b1; tx_data = 16'h00A5;
    @(negedge clk); start = 1'b0;
    chk(!busy && spi_cs_n, tag, busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && spi_cs_n && !done, tag, busy, 0);
  endtask

  task automatic xfer(input bit pha, input bit pol, input bit msb, input int n, input int rate,
                      input logic [15:0] tx, input logic [15:0] sw, input bit poke);
    int h, t0, last_t, e, guard, bad_t, bad_d, bad_dir;
    bit prev, lead, poked;
    logic [15:0] exp_rx;
    h = rate + 1; e = 0; guard = 0; bad_t = 0; bad_d = 0; bad_dir = 0; poked = 0;
    exp_rx = (n == 8) ? {8'h00, sw[7:0]} : sw;
    setup(pha, pol, msb, rate, n);
    @(negedge clk);
    chk(spi_sclk == pol, "R6 idle level before start", spi_sclk, pol);
    start = 1'b1; tx_data = tx;
    @(negedge clk); start = 1'b0;
    t0 = cyc; last_t = t0;
    chk(!spi_cs_n && busy, "R9 chip select asserted", spi_cs_n, 0);
    if (!pha) chk(spi_mosi == wbit(tx, n, msb, 0), "R7 first bit before first edge", spi_mosi, wbit(tx, n, msb, 0));
    spi_miso = wbit(sw, n, msb, 0);
    prev = spi_sclk;
    while (!done && guard < 5000) begin
      @(negedge clk); guard++;
      if (poke && e == 3 && !poked) begin
        start = 1'b1; tx_data = ~tx; cfg_mode = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0;
        reg_wdata = {13'd0, msb, ~pol, pha}; poked = 1;
      end else begin
        start = 1'b0; cfg_mode = 1'b0; reg_wr = 1'b0;
      end
      if (spi_sclk != prev) begin
        lead = (e % 2 == 0);
        if (cyc - last_t != h) bad_t++;
        if (lead && spi_sclk == pol) bad_dir++;
        if ((pha == 1'b0) == lead && spi_mosi != wbit(tx, n, msb, e / 2)) bad_d++;
        if (!pha && !lead && e / 2 + 1 < n) spi_miso = wbit(sw, n, msb, e / 2 + 1);
        if (pha && lead) spi_miso = wbit(sw, n, msb, e / 2);
        prev = spi_sclk; last_t = cyc; e++;
      end
    end
    start = 1'b0; cfg_mode = 1'b0; reg_wr = 1'b0;
    chk(done, "R9 done pulse seen", done, 1);
    chk(e == 2 * n, "R5 edge count", e, 2 * n);
    chk(bad_t == 0, "R5 half period spacing", bad_t, 0);
    chk(cyc - last_t == h, "R9 chip select trailing delay", cyc - last_t, h);
    chk(spi_cs_n, "R9 chip select released with done", spi_cs_n, 1);
    chk(bad_dir == 0, "R6 first edge leaves idle level", bad_dir, 0);
    chk(bad_d == 0, "R7 R8 MOSI bit on sampling edge", bad_d, 0);
    chk(rx_data == exp_rx, "R8 R9 received word", rx_data, exp_rx);
    @(negedge clk);
    chk(!done, "R9 done lasts one cycle", done, 0);
    chk(!busy && spi_cs_n, "R10 no transfer after ignored start", busy, 0);
    chk(spi_sclk == pol, "R2 R6 idle level unchanged after busy write", spi_sclk, pol);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !busy && !done && !spi_sclk, "R1 reset outputs", {spi_cs_n, busy, done, spi_sclk}, 4'b1000);
    try_refused("R1 start refused when unconfigured");

    wr(1'b1, {8'd1, 3'b000, 5'd8}, 1'b0);
    try_refused("R2 rate and size write outside config mode ignored");
    wr(1'b0, 16'h0002, 1'b0);
    @(negedge clk);
    chk(spi_sclk == 1'b0, "R2 polarity write outside config mode ignored", spi_sclk, 0);

    setup(1'b0, 1'b0, 1'b1, 0, 8);
    try_refused("R3 zero rate refused");
    setup(1'b0, 1'b0, 1'b1, 2, 12);
    try_refused("R4 size 12 refused");
    setup(1'b0, 1'b0, 1'b1, 2, 0);
    try_refused("R4 size 0 refused");

    xfer(1'b0, 1'b0, 1'b1, 8, 1, 16'h00A5, 16'h003C, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 16, 2, 16'h1234, 16'hBEEF, 1'b1);
    xfer(1'b1, 1'b0, 1'b1, 16, 1, 16'hC3A5, 16'h5A0F, 1'b0);
    xfer(1'b0, 1'b1, 1'b0, 8, 3, 16'h0081, 16'h00E7, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=%0h expected=%0h", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule